// File: doc/BRIEF.md
# ASCII line command LED decoder

This block watches a stream of received characters. Each character arrives on a parallel byte bus together with a one-cycle valid strobe. The block keeps the six most recent accepted characters in a sliding window. When an accepted character is a line feed, it compares that window with a small fixed set of text commands. A command names one colour. When the command is recognised, the block lights that colour on a three-colour indicator and raises a one-cycle strobe.

The block sits behind a serial receiver that has already assembled whole bytes. Because the match is made on a sliding window, the characters before a command on the same line do not matter, provided the last six characters form the command. A parameter sets the electrical polarity of the colour pins, so the same logic can drive common-anode or common-cathode indicators.

Top module: `line_cmd_led`

## Requirements
- R1: While reset is asserted, and in the cycle after it, all three colour outputs are at their inactive level and `cmd_valid` is 0.
- R2: The accepted sequence 0x4C 0x45 0x44 0x52 0x0D 0x0A ("LEDR", CR, LF) turns red on and green and blue off. The colour outputs change on the clock edge at which the LF byte is accepted.
- R3: The accepted sequence "LEDG", CR, LF (0x47 as the fourth byte) turns green on and the other two colours off.
- R4: The accepted sequence "LEDB", CR, LF (0x42 as the fourth byte) turns blue on and the other two colours off.
- R5: A byte enters the window only when `rx_valid` is 1. A byte presented with `rx_valid` at 0, including 0x0A, neither shifts the window nor triggers evaluation.
- R6: A line that ends in an accepted LF but does not match any command exactly (the comparison is case-sensitive, so "LEDb" fails) leaves the colour outputs unchanged and keeps `cmd_valid` at 0.
- R7: A command whose letters are followed directly by LF, without the CR (0x0D), is not recognised.
- R8: `cmd_valid` rises on the edge that accepts the LF of a recognised command and stays high for exactly one clock.
- R9: Reset clears the window to 0x00. Letters received before a reset therefore cannot combine with letters received after it to form a match.
- R10: With `LED_ACTIVE_HIGH` = 0, each colour output is the inverse of the output it would have with `LED_ACTIVE_HIGH` = 1.
- R11: A command preceded on the same line by other accepted bytes is still recognised, because only the newest six bytes are compared.
- R12: At most one colour is lit at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | Strobe: `rx_byte` holds a new character this cycle |
| rx_byte | input | 8 | Received character |
| led_r | output | 1 | Red enable, at the polarity set by `LED_ACTIVE_HIGH` |
| led_g | output | 1 | Green enable, at the polarity set by `LED_ACTIVE_HIGH` |
| led_b | output | 1 | Blue enable, at the polarity set by `LED_ACTIVE_HIGH` |
| cmd_valid | output | 1 | One-cycle pulse when a command is recognised |

## Verification
The window cannot be seen at the ports, so a fault in it shows up only on the next accepted line feed. That line feed is the edge at which a correct line either lights the wrong colour, fails to light any colour, or lights a colour that a mismatched line should not have lit. For this reason every stimulus pattern ends in an LF, and the outputs are checked one cycle after that LF. Faults in the held colour register or in the strobe appear on the first following cycle, so the held state is also checked on idle and non-LF cycles between lines.

// File: rtl/lcl_pkg.sv
package lcl_pkg;

    localparam int BYTE_W      = 8;
    localparam int CMD_LEN     = 6;
    localparam int NUM_COLOURS = 3;

    localparam logic [BYTE_W-1:0] CH_CR = 8'h0D;
    localparam logic [BYTE_W-1:0] CH_LF = 8'h0A;

    typedef enum int {
        COL_RED   = 0,
        COL_GREEN = 1,
        COL_BLUE  = 2
    } colour_e;

    typedef struct packed {
        logic [NUM_COLOURS-1:0] rgb;
        logic                   strobe;
    } led_state_t;

    function automatic logic [CMD_LEN*BYTE_W-1:0] cmd_pattern(int idx);
        logic [BYTE_W-1:0] tag;
        case (idx)
            COL_RED:   tag = 8'h52;
            COL_GREEN: tag = 8'h47;
            default:   tag = 8'h42;
        endcase
        return {8'h4C, 8'h45, 8'h44, tag, CH_CR, CH_LF};
    endfunction

endpackage

// File: rtl/lcl_window.sv
module lcl_window #(
    parameter int BYTE_W = 8,
    parameter int DEPTH  = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      valid,
    input  logic [BYTE_W-1:0]         char_in,
    output logic [DEPTH*BYTE_W-1:0]   win_next
);

    localparam int WIN_W = DEPTH * BYTE_W;

    logic [WIN_W-1:0] win_d;
    logic [WIN_W-1:0] win_q;

    // Newest byte goes into the least significant position.
    always_comb begin
        win_d = win_q;
        if (valid) begin
            win_d = {win_q[WIN_W-BYTE_W-1:0], char_in};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end

    assign win_next = win_d;

endmodule

// File: rtl/lcl_matcher.sv
module lcl_matcher #(
    parameter int BYTE_W   = 8,
    parameter int DEPTH    = 6,
    parameter int NUM_CMDS = 3
) (
    input  logic                      valid,
    input  logic [BYTE_W-1:0]         char_in,
    input  logic [DEPTH*BYTE_W-1:0]   window,
    output logic                      eol,
    output logic [NUM_CMDS-1:0]       hit
);

    assign eol = valid && (char_in == lcl_pkg::CH_LF);

    for (genvar k = 0; k < NUM_CMDS; k++) begin : g_cmp
        assign hit[k] = (window == lcl_pkg::cmd_pattern(k));
    end

endmodule

// File: rtl/lcl_led_state.sv
module lcl_led_state #(
    parameter int NUM_COLOURS = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   eol,
    input  logic [NUM_COLOURS-1:0] hit,
    output logic [NUM_COLOURS-1:0] rgb,
    output logic                   strobe
);

    lcl_pkg::led_state_t state_d;
    lcl_pkg::led_state_t state_q;
    logic [NUM_COLOURS-1:0] hit_msb_first;

    // hit index 0 is red; rgb is ordered {red, green, blue}.
    for (genvar k = 0; k < NUM_COLOURS; k++) begin : g_flip
        assign hit_msb_first[NUM_COLOURS-1-k] = hit[k];
    end

    always_comb begin
        state_d        = state_q;
        state_d.strobe = 1'b0;
        if (eol && (|hit)) begin
            state_d.rgb    = hit_msb_first;
            state_d.strobe = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rgb    = state_q.rgb;
    assign strobe = state_q.strobe;

endmodule

// File: rtl/line_cmd_led.sv
module line_cmd_led #(
    parameter bit LED_ACTIVE_HIGH = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rx_valid,
    input  logic [lcl_pkg::BYTE_W-1:0] rx_byte,
    output logic                       led_r,
    output logic                       led_g,
    output logic                       led_b,
    output logic                       cmd_valid
);

    localparam int BYTE_W = lcl_pkg::BYTE_W;
    localparam int DEPTH  = lcl_pkg::CMD_LEN;
    localparam int NCOL   = lcl_pkg::NUM_COLOURS;

    logic [DEPTH*BYTE_W-1:0] win_next;
    logic                    eol;
    logic [NCOL-1:0]         hit;
    logic [NCOL-1:0]         rgb;

    lcl_window #(.BYTE_W(BYTE_W), .DEPTH(DEPTH)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (rx_valid),
        .char_in  (rx_byte),
        .win_next (win_next)
    );

    lcl_matcher #(.BYTE_W(BYTE_W), .DEPTH(DEPTH), .NUM_CMDS(NCOL)) u_matcher (
        .valid   (rx_valid),
        .char_in (rx_byte),
        .window  (win_next),
        .eol     (eol),
        .hit     (hit)
    );

    lcl_led_state #(.NUM_COLOURS(NCOL)) u_state (
        .clk    (clk),
        .rst_n  (rst_n),
        .eol    (eol),
        .hit    (hit),
        .rgb    (rgb),
        .strobe (cmd_valid)
    );

    if (LED_ACTIVE_HIGH) begin : g_pol_high
        assign {led_r, led_g, led_b} = rgb;
    end else begin : g_pol_low
        assign {led_r, led_g, led_b} = ~rgb;
    end

endmodule

// File: rtl/lcl_checker.sv
module lcl_checker #(
    parameter bit ACTIVE_HIGH = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic [7:0] rx_byte,
    input logic       led_r,
    input logic       led_g,
    input logic       led_b,
    input logic       cmd_valid
);

    logic [2:0] lit;
    assign lit = ACTIVE_HIGH ? {led_r, led_g, led_b} : ~{led_r, led_g, led_b};

    // R1
    reset_dark_chk: assert property (@(posedge clk)
        !rst_n |=> (lit == 3'b000 && !cmd_valid));

    // R8
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R5
    strobe_after_lf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(rx_valid && rx_byte == 8'h0A));

    // R6
    hold_without_lf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && rx_byte == 8'h0A) |=> ($stable(lit) && !cmd_valid));

    // R2
    strobe_one_colour_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ($countones(lit) == 1));

    // R12
    one_hot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lit));

endmodule

bind line_cmd_led lcl_checker #(.ACTIVE_HIGH(LED_ACTIVE_HIGH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .led_r     (led_r),
    .led_g     (led_g),
    .led_b     (led_b),
    .cmd_valid (cmd_valid)
);

// File: tb/test_line_cmd_led.sv
module test_line_cmd_led;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       led_r, led_g, led_b, cmd_valid;
    logic       nled_r, nled_g, nled_b, ncmd_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    line_cmd_led #(.LED_ACTIVE_HIGH(1'b1)) i_line_cmd_led (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .led_r(led_r), .led_g(led_g), .led_b(led_b), .cmd_valid(cmd_valid)
    );

    line_cmd_led #(.LED_ACTIVE_HIGH(1'b0)) i_line_cmd_led_low (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .led_r(nled_r), .led_g(nled_g), .led_b(nled_b), .cmd_valid(ncmd_valid)
    );

    // {valid, byte, expected {r,g,b}, expected cmd_valid}
    localparam int NV = 46;
    localparam logic [12:0] VEC [NV] = '{
        // R2: LEDR CR LF
        {1'b1, 8'h4C, 3'b000, 1'b0}, {1'b1, 8'h45, 3'b000, 1'b0},
        {1'b1, 8'h44, 3'b000, 1'b0}, {1'b1, 8'h52, 3'b000, 1'b0},
        {1'b1, 8'h0D, 3'b000, 1'b0}, {1'b1, 8'h0A, 3'b100, 1'b1},
        // R8: strobe drops on the next cycle
        {1'b0, 8'h00, 3'b100, 1'b0},
        // R3: LEDG CR LF
        {1'b1, 8'h4C, 3'b100, 1'b0}, {1'b1, 8'h45, 3'b100, 1'b0},
        {1'b1, 8'h44, 3'b100, 1'b0}, {1'b1, 8'h47, 3'b100, 1'b0},
        {1'b1, 8'h0D, 3'b100, 1'b0}, {1'b1, 8'h0A, 3'b010, 1'b1},
        // R6: LEDb CR LF, case mismatch
        {1'b1, 8'h4C, 3'b010, 1'b0}, {1'b1, 8'h45, 3'b010, 1'b0},
        {1'b1, 8'h44, 3'b010, 1'b0}, {1'b1, 8'h62, 3'b010, 1'b0},
        {1'b1, 8'h0D, 3'b010, 1'b0}, {1'b1, 8'h0A, 3'b010, 1'b0},
        // R7: LEDB LF without CR
        {1'b1, 8'h4C, 3'b010, 1'b0}, {1'b1, 8'h45, 3'b010, 1'b0},
        {1'b1, 8'h44, 3'b010, 1'b0}, {1'b1, 8'h42, 3'b010, 1'b0},
        {1'b1, 8'h0A, 3'b010, 1'b0},
        // R11 and R4: xxLEDB CR LF
        {1'b1, 8'h78, 3'b010, 1'b0}, {1'b1, 8'h78, 3'b010, 1'b0},
        {1'b1, 8'h4C, 3'b010, 1'b0}, {1'b1, 8'h45, 3'b010, 1'b0},
        {1'b1, 8'h44, 3'b010, 1'b0}, {1'b1, 8'h42, 3'b010, 1'b0},
        {1'b1, 8'h0D, 3'b010, 1'b0}, {1'b1, 8'h0A, 3'b001, 1'b1},
        // R5: LF with valid low is ignored, the valid LF then matches
        {1'b1, 8'h4C, 3'b001, 1'b0}, {1'b1, 8'h45, 3'b001, 1'b0},
        {1'b1, 8'h44, 3'b001, 1'b0}, {1'b1, 8'h52, 3'b001, 1'b0},
        {1'b1, 8'h0D, 3'b001, 1'b0}, {1'b0, 8'h0A, 3'b001, 1'b0},
        {1'b1, 8'h0A, 3'b100, 1'b1},
        // R5: a byte with valid low does not enter the window
        {1'b1, 8'h4C, 3'b100, 1'b0}, {1'b1, 8'h45, 3'b100, 1'b0},
        {1'b0, 8'h5A, 3'b100, 1'b0}, {1'b1, 8'h44, 3'b100, 1'b0},
        {1'b1, 8'h47, 3'b100, 1'b0}, {1'b1, 8'h0D, 3'b100, 1'b0},
        {1'b1, 8'h0A, 3'b010, 1'b1}
    };

    task automatic check(string req, logic [3:0] got, logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got rgb/strobe=%b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic check_pol();
        check("R10", {nled_r, nled_g, nled_b, ncmd_valid},
              {~led_r, ~led_g, ~led_b, cmd_valid});
    endtask

    task automatic send(logic v, logic [7:0] b);
        @(negedge clk);
        rx_valid = v;
        rx_byte  = b;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", {led_r, led_g, led_b, cmd_valid}, 4'b0000);
        check_pol();
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1", {led_r, led_g, led_b, cmd_valid}, 4'b0000);

        for (int i = 0; i < NV; i++) begin
            send(VEC[i][12], VEC[i][11:4]);
            check($sformatf("R2-R8,R11 vector %0d", i),
                  {led_r, led_g, led_b, cmd_valid}, VEC[i][3:0]);
            check_pol();
        end

        // R9: letters before a reset must not complete a command after it
        send(1'b1, 8'h4C);
        send(1'b1, 8'h45);
        send(1'b1, 8'h44);
        @(negedge clk);
        rx_valid = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1", {led_r, led_g, led_b, cmd_valid}, 4'b0000);
        check_pol();
        @(negedge clk);
        rst_n = 1'b1;
        send(1'b1, 8'h52);
        send(1'b1, 8'h0D);
        send(1'b1, 8'h0A);
        check("R9", {led_r, led_g, led_b, cmd_valid}, 4'b0000);

        // R4: a full blue command after reset
        send(1'b1, 8'h4C);
        send(1'b1, 8'h45);
        send(1'b1, 8'h44);
        send(1'b1, 8'h42);
        send(1'b1, 8'h0D);
        send(1'b1, 8'h0A);
        check("R4", {led_r, led_g, led_b, cmd_valid}, 4'b0011);
        check_pol();
        send(1'b0, 8'h00);
        check("R8", {led_r, led_g, led_b, cmd_valid}, 4'b0010);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired got running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule